// File: doc/BRIEF.md
# Low-Voltage Reset Supervisor

This block is the digital side of a supply-voltage monitor. Two comparators outside the block digitise the supply. One reports that the supply has dropped below the falling threshold. The other reports that it has climbed above the rising threshold, which sits higher. The block synchronises both results to its clock. From them it drives a system reset request and a status flag that software can poll. It also drives a range-select level that tells the analog side which pair of thresholds to use.

Software sets the behaviour through a 4-bit configuration register, and that register can be written only once. After power-on the monitor is enabled, it may assert reset, it is suspended in stop mode and it uses the low range. The first write after power-on loads all four bits and locks the register. Every later write is ignored until the next power-on reset. The reset request that the block itself raises does not clear the lock. Once the supply has dropped low, reset stays asserted until the supply crosses the rising threshold and stays above it for a fixed hold time. This hysteresis stops the system from entering and leaving reset over and over while the supply sits near a single threshold.

Top module: `lvr_supervisor`

## Requirements
- R1: After power-on reset, `sys_rst_req`, `supply_low` and `range_hi` are 0 and the register is unlocked. Without any write, the monitor is armed: a low supply asserts reset.
- R2: Each comparator input passes through two synchronising flops. A change applied before clock edge k reaches `supply_low` and `sys_rst_req` at edge k+2, and not before.
- R3: With power-disable (bit 0) and reset-disable (bit 1) both clear, a low supply asserts `sys_rst_req` and sets `supply_low`.
- R4: Once reset is asserted, it stays asserted after the low indication clears, for as long as the rising comparator stays 0. `supply_low` follows the falling comparator during this time.
- R5: Reset is released only after the synchronised rising indication has been 1 for 16 consecutive cycles with no low indication. If the rising indication drops, or a low indication returns, the block goes back to waiting.
- R6: With reset-disable (bit 1) set, `supply_low` still follows the falling comparator, but `sys_rst_req` is never asserted. This is polled mode.
- R7: With power-disable (bit 0) set, the monitor is off: `supply_low` holds its value and `sys_rst_req` stays 0.
- R8: In stop mode with stop-enable (bit 2) clear, monitoring is suspended: `supply_low` holds its value and no reset is started. Leaving stop mode resumes monitoring on the next edge.
- R9: In stop mode with stop-enable (bit 2) set, monitoring continues and a low supply asserts reset.
- R10: Only the first write after power-on takes effect. Later writes change no bit, so neither the range nor the modes can change.
- R11: `range_hi` drives the value of the trip-range bit (bit 3): 0 selects the low range and 1 selects the high range.
- R12: The write lock is cleared only by `por_n`, not by a reset cycle that the block generates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears configuration and lock |
| cmp_below_fall | input | 1 | Asynchronous comparator output: supply below the falling threshold |
| cmp_above_rise | input | 1 | Asynchronous comparator output: supply above the rising threshold |
| stop_mode | input | 1 | System is in stop mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Write data: bit0 power-disable, bit1 reset-disable, bit2 stop-enable, bit3 trip-range |
| sys_rst_req | output | 1 | System reset request |
| supply_low | output | 1 | Pollable low-supply status flag |
| range_hi | output | 1 | Threshold range select to the analog side |

## Verification
The assertions check these rules on every cycle:
- A reset can only rise after a synchronised low indication, and it never rises while power-disable or reset-disable is set, or while monitoring is suspended in stop mode.
- Reset never falls without a run of at least 16 rising-indication cycles.
- Once locked, the configuration and the range output never change.

The bench scenarios show what the assertions cannot:
- the exact edge on which reset rises and falls;
- that a repeated write after a self-generated reset is ignored;
- that a fresh power-on reset unlocks the register;
- that status holds while monitoring is off.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

  // Configuration bit layout: bit3 trip range, bit2 stop enable,
  // bit1 reset disable, bit0 power disable.
  typedef struct packed {
    logic range_hi;
    logic stop_en;
    logic rst_dis;
    logic pwr_dis;
  } lvr_cfg_t;

  localparam int unsigned CFG_W = $bits(lvr_cfg_t);

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_TRIPPED = 2'd1,
    ST_RECOVER = 2'd2
  } lvr_state_e;

endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lvr_cfg_reg.sv
module lvr_cfg_reg
  import lvr_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output lvr_cfg_t         cfg,
  output logic             locked
);

  lvr_cfg_t cfg_q;
  logic     lock_q;

  // Only power-on reset clears the lock; the block's own reset
  // request has no path back into this register.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_en && !lock_q) begin
      cfg_q  <= lvr_cfg_t'(wr_data);
      lock_q <= 1'b1;
    end
  end

  assign cfg    = cfg_q;
  assign locked = lock_q;

endmodule

// File: rtl/lvr_hyst_fsm.sv
module lvr_hyst_fsm
  import lvr_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic monitor_on,   // monitoring active this cycle
  input  logic force_off,    // monitor powered down
  input  logic rst_allow,    // resets may be issued
  input  logic low_s,
  input  logic high_s,
  output logic rst_req,
  output logic status_low
);

  localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  lvr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (force_off) begin
      state_d = ST_ARMED;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ARMED: begin
          if (monitor_on && rst_allow && low_s) state_d = ST_TRIPPED;
        end
        ST_TRIPPED: begin
          if (high_s && !low_s) begin
            state_d = ST_RECOVER;
            cnt_d   = '0;
          end
        end
        ST_RECOVER: begin
          if (low_s || !high_s) begin
            state_d = ST_TRIPPED;
          end else if (cnt_q == CNT_LAST) begin
            state_d = ST_ARMED;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (monitor_on) stat_q <= low_s;
    end
  end

  assign rst_req    = (state_q != ST_ARMED);
  assign status_low = stat_q;

endmodule

// File: rtl/lvr_supervisor.sv
module lvr_supervisor
  import lvr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cmp_below_fall,
  input  logic             cmp_above_rise,
  input  logic             stop_mode,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             sys_rst_req,
  output logic             supply_low,
  output logic             range_hi
);

  lvr_cfg_t   cfg_q;
  logic       cfg_locked;
  logic [1:0] cmp_raw, cmp_s;
  logic       lo_s, hi_s;
  logic       mon_on;

  assign cmp_raw = {cmp_above_rise, cmp_below_fall};

  lvr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (cmp_raw),
    .q     (cmp_s)
  );

  assign lo_s = cmp_s[0];
  assign hi_s = cmp_s[1];

  lvr_cfg_reg u_cfg (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg_q),
    .locked  (cfg_locked)
  );

  assign mon_on = !cfg_q.pwr_dis && (!stop_mode || cfg_q.stop_en);

  lvr_hyst_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .monitor_on (mon_on),
    .force_off  (cfg_q.pwr_dis),
    .rst_allow  (!cfg_q.rst_dis),
    .low_s      (lo_s),
    .high_s     (hi_s),
    .rst_req    (sys_rst_req),
    .status_low (supply_low)
  );

  assign range_hi = cfg_q.range_hi;

endmodule

// File: rtl/lvr_supervisor_chk.sv
module lvr_supervisor_chk
  import lvr_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic     clk,
  input logic     por_n,
  input lvr_cfg_t cfg,
  input logic     locked,
  input logic     lo_s,
  input logic     hi_s,
  input logic     stop_mode,
  input logic     rst,
  input logic     range_out
);

  int unsigned hi_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             hi_run <= 0;
    else if (rst && hi_s)   hi_run <= hi_run + 1;
    else                    hi_run <= 0;
  end

  assert_rise_needs_low_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst) |-> $past(lo_s));

  assert_hold_without_rise_R4: assert property (@(posedge clk) disable iff (!por_n)
    $past(rst) && !$past(hi_s) |-> rst);

  assert_release_after_run_R5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst) |-> hi_run >= HOLD_CYCLES);

  assert_polled_no_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    cfg.rst_dis && !rst |=> !rst);

  assert_powered_down_R7: assert property (@(posedge clk) disable iff (!por_n)
    cfg.pwr_dis |=> !rst);

  assert_stop_suspend_R8: assert property (@(posedge clk) disable iff (!por_n)
    stop_mode && !cfg.stop_en && !rst |=> !rst);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> $stable(cfg) && locked);

  assert_range_follows_R11: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> $stable(range_out));

endmodule

bind lvr_supervisor lvr_supervisor_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .cfg       (cfg_q),
  .locked    (cfg_locked),
  .lo_s      (lo_s),
  .hi_s      (hi_s),
  .stop_mode (stop_mode),
  .rst       (sys_rst_req),
  .range_out (range_hi)
);

// File: tb/lvr_supervisor_test.sv
`timescale 1ns/1ps
module lvr_supervisor_test;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       lo = 1'b0, hi = 1'b0, stop = 1'b0, we = 1'b0;
  logic [3:0] wdata = '0;
  logic       rst_o, stat_o, range_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic  rst;
    logic  stat;
    logic  rng;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  lvr_supervisor uut (
    .clk            (clk),
    .por_n          (por_n),
    .cmp_below_fall (lo),
    .cmp_above_rise (hi),
    .stop_mode      (stop),
    .cfg_we         (we),
    .cfg_wdata      (wdata),
    .sys_rst_req    (rst_o),
    .supply_low     (stat_o),
    .range_hi       (range_o)
  );

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        tests++;
        if (rst_o !== e.rst || stat_o !== e.stat || range_o !== e.rng) begin
          fails++;
          $display("FAIL %s: got rst=%b low=%b range=%b, expected rst=%b low=%b range=%b",
                   e.tag, rst_o, stat_o, range_o, e.rst, e.stat, e.rng);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_out(input logic r, input logic s, input logic g, input string tag);
    exp_t e;
    e.rst = r; e.stat = s; e.rng = g; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drive(input logic l, input logic h, input logic st);
    @(negedge clk);
    lo = l; hi = h; stop = st;
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 1'b0; lo = 1'b0; hi = 1'b0; stop = 1'b0; we = 1'b0;
    tick(2);
    @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [3:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // Supply goes back up: drop low, raise high, wait for release.
  task automatic recover(input logic g, input string tag);
    drive(1'b0, 1'b1, 1'b0);
    tick(18);
    expect_out(1'b1, 1'b0, g, {tag, " still held"});
    tick(1);
    expect_out(1'b0, 1'b0, g, {tag, " released"});
    drive(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    power_on();
    tick(1);
    expect_out(1'b0, 1'b0, 1'b0, "R1 reset state");

    // Forced-reset mode, synchroniser latency
    write_cfg(4'b0000);
    drive(1'b1, 1'b0, 1'b0);
    tick(2);
    expect_out(1'b0, 1'b0, 1'b0, "R2 not yet through synchroniser");
    tick(1);
    expect_out(1'b1, 1'b1, 1'b0, "R3 low supply asserts reset (R2 edge k+2)");

    // Hysteresis: low clears, rising not reached
    drive(1'b0, 1'b0, 1'b0);
    tick(30);
    expect_out(1'b1, 1'b0, 1'b0, "R4 reset held below rising threshold");

    // Rising crossed but interrupted before the hold count ends
    drive(1'b0, 1'b1, 1'b0);
    tick(10);
    drive(1'b0, 1'b0, 1'b0);
    tick(20);
    expect_out(1'b1, 1'b0, 1'b0, "R5 interrupted rise keeps reset");

    recover(1'b0, "R5 hold count");

    // Write after a self-generated reset must be ignored
    write_cfg(4'b1010);
    tick(2);
    expect_out(1'b0, 1'b0, 1'b0, "R12 lock survives own reset, R10 range unchanged");
    drive(1'b1, 1'b0, 1'b0);
    tick(3);
    expect_out(1'b1, 1'b1, 1'b0, "R10 ignored reset-disable, reset still issued");
    recover(1'b0, "R10 second trip");

    // Fresh power-on unlocks: polled mode, high range
    power_on();
    write_cfg(4'b1010);
    tick(1);
    expect_out(1'b0, 1'b0, 1'b1, "R11 high range selected");
    drive(1'b1, 1'b0, 1'b0);
    tick(3);
    expect_out(1'b0, 1'b1, 1'b1, "R6 polled flag set without reset");
    drive(1'b0, 1'b0, 1'b0);
    tick(3);
    expect_out(1'b0, 1'b0, 1'b1, "R6 polled flag clears");
    write_cfg(4'b0000);
    tick(1);
    expect_out(1'b0, 1'b0, 1'b1, "R10 range kept after second write");

    // Power-disable
    power_on();
    write_cfg(4'b0001);
    drive(1'b1, 1'b0, 1'b0);
    tick(6);
    expect_out(1'b0, 1'b0, 1'b0, "R7 monitor off");

    // Stop mode without stop-enable
    power_on();
    write_cfg(4'b0000);
    drive(1'b1, 1'b0, 1'b1);
    tick(6);
    expect_out(1'b0, 1'b0, 1'b0, "R8 suspended in stop");
    drive(1'b1, 1'b0, 1'b0);
    tick(1);
    expect_out(1'b1, 1'b1, 1'b0, "R8 resumes after stop");
    recover(1'b0, "R8 recovery");

    // Stop mode with stop-enable
    power_on();
    write_cfg(4'b0100);
    drive(1'b1, 1'b0, 1'b1);
    tick(3);
    expect_out(1'b1, 1'b1, 1'b0, "R9 active in stop");
    recover(1'b0, "R9 recovery");

    // No write at all: default enabled
    power_on();
    drive(1'b1, 1'b0, 1'b0);
    tick(3);
    expect_out(1'b1, 1'b1, 1'b0, "R1 default monitor armed");
    recover(1'b0, "R1 recovery");

    tick(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule